// File: doc/BRIEF.md
# Byte/Word Asynchronous ROM Read Controller

This block runs on a system clock and reads an external parallel ROM that has no clock of its own. The host presents a byte address and a mode bit with a single-cycle request while the controller shows ready. The controller then returns the data with a one-cycle done pulse. In word mode the result is sixteen bits read from the data pins. In byte mode the result is eight bits, zero-extended. In byte mode the ROM's top data pin becomes an address input: the controller drives it with the lowest address bit and reads only the low eight data lines.

Each read walks a fixed sequence of states. In SETUP the address, the mode line and the active-low chip enable are driven. In ACCESS the active-low output enable is asserted and a cycle count is held while the ROM settles. SAMPLE captures the data. RELEASE drops both enables and waits while the ROM lets go of the bus. The wait lengths are parameters in clock cycles, rounded up from the ROM's access and float times at the chosen clock period.

Top module: `romrd_ctrl`

## Requirements
- R1: Out of reset `rdy` is 1, `done` is 0, `mem_ce_n` and `mem_oe_n` are 1, and the controller does not drive `mem_q15`. `rdy` is 1 exactly when the controller is idle, and in that state both enables are 1.
- R2: A request (`req_valid`=1 at a rising edge) is taken only at an edge where `rdy` is 1. A request held or presented while `rdy` is 0 has no effect on any output.
- R3: In the first cycle after acceptance, `mem_ce_n` is 0 and `mem_oe_n` is still 1. `mem_addr` is `req_addr[ADDR_W:0]` without bit 0, i.e. bits ADDR_W down to 1.
- R4: `mem_oe_n` is 0 for exactly ACC_CYC+1 cycles, starting in the second cycle after acceptance. Data is captured at the end of the last of these cycles.
- R5: With `req_byte`=0 (word mode), `mem_word` is 1 and the controller never drives `mem_q15`. `rd_data` then equals {`mem_q15`, `mem_d[14:0]`} as captured.
- R6: With `req_byte`=1 (byte mode), `mem_word` is 0 and `mem_q15` is driven with `req_addr[0]` for the whole read. `rd_data` is {8'h00, `mem_d[7:0]`}. `mem_d[14:8]` has no effect.
- R7: `done` is high for exactly one cycle per accepted request, in the cycle after the last output-enable cycle. `rd_data` is valid in that cycle.
- R8: From the `done` cycle on, both enables are 1 for REL_CYC cycles before `rdy` returns to 1.
- R9: `mem_addr` and `mem_word` stay constant from acceptance until the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request |
| req_byte | input | 1 | 1 = byte read, 0 = word read |
| req_addr | input | ADDR_W+1 | Byte address; bit 0 selects the byte in byte mode |
| rdy | output | 1 | Idle, a request will be taken |
| done | output | 1 | One-cycle pulse, `rd_data` valid |
| rd_data | output | DATA_W | Read result |
| mem_ce_n | output | 1 | ROM chip enable, active low |
| mem_oe_n | output | 1 | ROM output enable, active low |
| mem_word | output | 1 | ROM width select, 1 = word |
| mem_addr | output | ADDR_W | ROM address |
| mem_d | input | DATA_W-1 | ROM data lines 0 to 14 |
| mem_q15 | inout | 1 | ROM data line 15 / lowest byte-address bit |

## Verification
The collision of interest is the return to idle coinciding with a new request. The bench holds `req_valid` high with a fresh address through a whole read. The held request is ignored while busy, and it must be accepted on the very edge where `rdy` is back at 1. The reference model follows the same rule, and its predicted enables, `done` timing and data are compared every cycle. The behavioural ROM returns a poison value until the output enable has been low long enough, so sampling one cycle early is caught. In byte mode the ROM fills lines 8 to 14 with ones, so these lines leaking into the result are caught as well.

// File: rtl/romrd_pkg.sv
package romrd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_SAMPLE,
    ST_RELEASE
  } rd_state_t;
endpackage

// File: rtl/romrd_timer.sv
module romrd_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/romrd_pinio.sv
module romrd_pinio #(
  parameter int DATA_W = 16
) (
  input  logic              byte_mode,
  input  logic [DATA_W-2:0] d_low,
  input  logic              q15_in,
  output logic [DATA_W-1:0] rd_word
);
  localparam int BYTE_W = DATA_W / 2;

  generate
    if (BYTE_W < DATA_W) begin : g_split
      always_comb begin
        if (byte_mode) rd_word = {{(DATA_W-BYTE_W){1'b0}}, d_low[BYTE_W-1:0]};
        else           rd_word = {q15_in, d_low};
      end
    end
  endgenerate
endmodule

// File: rtl/romrd_ctrl.sv
module romrd_ctrl #(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int ACC_CYC = 20,
  parameter int REL_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_byte,
  input  logic [ADDR_W:0]   req_addr,
  output logic              rdy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_word,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-2:0] mem_d,
  inout  wire               mem_q15
);
  import romrd_pkg::*;

  localparam int MAX_CYC = (ACC_CYC > REL_CYC) ? ACC_CYC : REL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  rd_state_t         state_q;
  logic              q15_en_q;
  logic              q15_out_q;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              t_zero;
  logic [DATA_W-1:0] rd_word;

  assign mem_q15 = q15_en_q ? q15_out_q : 1'bz;
  assign rdy     = (state_q == ST_IDLE);

  assign t_load = (state_q == ST_SETUP) || (state_q == ST_SAMPLE);
  assign t_val  = (state_q == ST_SETUP) ? CNT_W'(ACC_CYC - 1) : CNT_W'(REL_CYC - 1);

  romrd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  romrd_pinio #(.DATA_W(DATA_W)) u_pinio (
    .byte_mode (~mem_word),
    .d_low     (mem_d),
    .q15_in    (mem_q15),
    .rd_word   (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_word  <= 1'b1;
      mem_addr  <= '0;
      q15_en_q  <= 1'b0;
      q15_out_q <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q   <= ST_SETUP;
            mem_ce_n  <= 1'b0;
            mem_word  <= ~req_byte;
            mem_addr  <= req_addr[ADDR_W:1];
            q15_en_q  <= req_byte;
            q15_out_q <= req_addr[0];
          end
        end
        ST_SETUP: begin
          state_q  <= ST_ACCESS;
          mem_oe_n <= 1'b0;
        end
        ST_ACCESS: begin
          if (t_zero) state_q <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          rd_data  <= rd_word;
          done     <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          state_q  <= ST_RELEASE;
        end
        ST_RELEASE: begin
          if (t_zero) begin
            state_q  <= ST_IDLE;
            q15_en_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/romrd_ctrl_chk.sv
module romrd_ctrl_chk #(
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              rdy,
  input logic              done,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_word,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              q15_en
);
  // R1: idle means both enables off and the shared pin released
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    rdy |-> (mem_ce_n && mem_oe_n && !q15_en));

  // R3: output enable only falls after chip enable was already active
  a_r3_ce_before_oe: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_ce_n));

  // R5: pin driver never on in word mode
  a_r5_no_contention: assert property (@(posedge clk) disable iff (rst)
    q15_en |-> !mem_word);

  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: enables already released when done shows, and still busy
  a_r8_released_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_ce_n && mem_oe_n && !rdy));

  // R9: address and mode hold while a read is in flight
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (!rdy && !$past(rdy)) |-> ($stable(mem_addr) && $stable(mem_word)));
endmodule

bind romrd_ctrl romrd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rdy      (rdy),
  .done     (done),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_word (mem_word),
  .mem_addr (mem_addr),
  .q15_en   (q15_en_q)
);

// File: tb/romrd_ctrl_tb.sv
`timescale 1ns/1ps
module romrd_ctrl_tb;
  localparam int AW  = 22;
  localparam int DW  = 16;
  localparam int ACC = 20;
  localparam int REL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_byte = 1'b0;
  logic [AW:0]   req_addr = '0;
  logic          rdy, done;
  logic [DW-1:0] rd_data;
  logic          mem_ce_n, mem_oe_n, mem_word;
  logic [AW-1:0] mem_addr;
  logic [DW-2:0] mem_d;
  wire           mem_q15;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  romrd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .REL_CYC(REL)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_byte(req_byte),
    .req_addr(req_addr), .rdy(rdy), .done(done), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_d(mem_d), .mem_q15(mem_q15)
  );

  // ---------------- behavioural ROM ----------------
  function automatic logic [15:0] rom_word(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], 10'h2B5} ^ 16'h5A3C;
  endfunction

  int oe_cnt = 0;
  always @(posedge clk) oe_cnt <= mem_oe_n ? 0 : oe_cnt + 1;

  logic [15:0] rom_w;
  logic        rom_q15_en;
  always_comb begin
    rom_w      = (oe_cnt >= ACC) ? rom_word(mem_addr) : 16'hDEAD;
    rom_q15_en = !mem_ce_n && !mem_oe_n && mem_word;
    if (!mem_ce_n && !mem_oe_n) begin
      if (mem_word) mem_d = rom_w[14:0];
      else          mem_d = {7'h7F, (mem_q15 ? rom_w[15:8] : rom_w[7:0])};
    end else begin
      mem_d = '0;
    end
  end
  assign mem_q15 = rom_q15_en ? rom_w[15] : 1'bz;

  // ---------------- reference model ----------------
  int            k = 0;
  logic          e_byte;
  logic [AW:0]   e_addr;
  localparam int LAST = ACC + 2 + REL;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else if (k == 0) begin
      if (req_valid) begin
        k <= 1; e_byte <= req_byte; e_addr <= req_addr;
      end
    end else k <= (k == LAST) ? 0 : k + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic e_rdy, e_ce, e_oe, e_done;
      logic [15:0] w, e_data;
      e_rdy  = (k == 0);
      e_ce   = !(k >= 1 && k <= ACC + 2);
      e_oe   = !(k >= 2 && k <= ACC + 2);
      e_done = (k == ACC + 3);
      chk(rdy === e_rdy, "R1/R2 rdy", rdy, e_rdy);
      chk(mem_ce_n === e_ce, "R3/R8 mem_ce_n", mem_ce_n, e_ce);
      chk(mem_oe_n === e_oe, "R4/R8 mem_oe_n", mem_oe_n, e_oe);
      chk(done === e_done, "R7 done", done, e_done);
      if (k != 0) begin
        chk(mem_addr === e_addr[AW:1], "R3/R9 mem_addr", mem_addr, e_addr[AW:1]);
        chk(mem_word === !e_byte, "R5/R6/R9 mem_word", mem_word, !e_byte);
        if (e_byte) chk(mem_q15 === e_addr[0], "R6 q15 address bit", mem_q15, e_addr[0]);
      end
      if (e_done) begin
        w = rom_word(e_addr[AW:1]);
        if (e_byte) e_data = {8'h00, (e_addr[0] ? w[15:8] : w[7:0])};
        else        e_data = w;
        chk(rd_data === e_data, e_byte ? "R6 byte data" : "R5 word data", rd_data, e_data);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic b, input logic [AW:0] a, input int linger, input logic [AW:0] a2);
    do @(negedge clk); while (!rdy);
    req_valid = 1'b1; req_byte = b; req_addr = a;
    @(negedge clk);
    if (linger > 0) begin
      req_addr = a2; req_byte = ~b;
      repeat (linger) @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdy === 1'b1 && mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && done === 1'b0,
        "R1 reset state", {rdy, mem_ce_n, mem_oe_n, done}, 4'b1110);
    issue(1'b0, 23'h000000, 0, '0);
    issue(1'b0, 23'h7FFFFE, 0, '0);
    issue(1'b1, 23'h000000, 0, '0);
    issue(1'b1, 23'h000001, 0, '0);
    issue(1'b1, 23'h7FFFFF, 0, '0);
    issue(1'b0, 23'h2AAAAA, 0, '0);
    // R2: requests held while busy are ignored; the held one lands on the idle edge
    issue(1'b0, 23'h123456, ACC + REL + 6, 23'h0ABCDF);
    issue(1'b1, 23'h155555, 8, 23'h3C3C3C);
    for (int i = 0; i < 12; i++)
      issue(i[0], 23'((i * 32'h0005_1B37) ^ 32'h0004_2F11), 0, '0);
    do @(negedge clk); while (!rdy);
    repeat (10) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      nerr++;
      $display("FAIL watchdog expired, run hung");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule